// File: doc/BRIEF.md
# Microwire serial EEPROM slave controller

This block holds the control logic of a three-wire serial EEPROM. A host drives a chip select, a serial clock and a data-in line. The block returns read data and program status on one data-out line, which it can tri-state. A fast system clock samples all three serial inputs and finds the rising edges of the serial clock. While selected, the block waits for a start bit, then shifts in an opcode, an address and, for write-type commands, one data word. It decodes seven commands and runs them on a small internal word array.

Program commands (write, erase, fill-all, erase-all) run only when the write-enable latch is set. Each one starts a self-timed program cycle of `PROG_CYCLES` system clocks, and no start bit is accepted until that cycle ends. Status appears on data-out only when the host deselects for at least `CSL_MIN` system clocks and then selects again: low means busy, high means ready. The word width `WORD_W` (8 or 16) sets the address width: 8 bits for 8-bit words, 7 bits for 16-bit words.

Data-out is a plain level `sdo` with an enable `sdo_en`; the pad drives the line only while `sdo_en` is high. The serial pins carry no handshake. The host paces every transfer with its own clock, so nothing here can apply back-pressure.

Top module: `mw_eeprom_ctrl`

## Requirements
- R1: After reset, `sdo_en` is low, every word reads as all ones and the write-enable latch is clear.
- R2: While selected and before a start bit, any number of serial clocks with `sdi` low change nothing and leave `sdo_en` low. The first 1 sampled on a rising serial-clock edge is the start bit.
- R3: After the start bit the frame carries three fields, each sent most significant bit first: a 2-bit opcode (10 read, 01 write, 11 erase), one ignored bit, then the address. A write then takes one data word, also MSB first. With 8-bit words, a write frame is 20 clocks and stores the word at the address. With 16-bit words it is 27 clocks.
- R4: Read is a 12-clock frame with 8-bit words and an 11-clock frame with 16-bit words. On the rising edge that samples the last address bit, data-out starts driving the word MSB first. Each later rising edge moves to the next bit. The rising edge after the last bit releases data-out to high impedance.
- R5: With opcode 00, the two most significant address bits pick the command: 11 enables writes, 00 disables writes, 01 fills every word with the following data word, and 10 sets every word to all ones.
- R6: While the write-enable latch is clear, write, erase, fill-all and erase-all change no word and start no program cycle.
- R7: Erase sets every bit of the addressed word to 1 and leaves the other words unchanged.
- R8: During a program cycle, if chip select is low for at least `CSL_MIN` clocks and then rises, data-out drives low while busy. Once the cycle ends, data-out drives high.
- R9: If chip select stays low for the whole program cycle, `sdo_en` stays low.
- R10: A program cycle finishes after `PROG_CYCLES` system clocks with no serial clocks and with chip select low. After a long enough low time, raising chip select shows ready at once.
- R11: Dropping chip select in the middle of a frame abandons the command, and no word changes.
- R12: After a frame has taken its full clock count, further clocks and data bits are ignored until chip select is toggled, including bits that form a valid command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select, high selects |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Data-out level (read data or ready/busy) |
| sdo_en | output | 1 | High when data-out is driven, low for high impedance |

## Verification
The bench builds the block with 8-bit words, a 40-clock program cycle and a 3-clock minimum deselect time. Words this narrow give an address space of only 256 entries. That makes it cheap to write every address with a value computed from the address and then read every one back. The short program cycle means status can be polled after each of those writes. Busy-then-ready is checked over the full sweep, and the held-low, abort, erase-all and trailing-clock cases are each run once.

// File: rtl/mw_pkg.sv
package mw_pkg;

  typedef enum logic [2:0] {
    CMD_NONE      = 3'd0,
    CMD_READ      = 3'd1,
    CMD_WRITE     = 3'd2,
    CMD_ERASE     = 3'd3,
    CMD_EN_WR     = 3'd4,
    CMD_DIS_WR    = 3'd5,
    CMD_FILL_ALL  = 3'd6,
    CMD_ERASE_ALL = 3'd7
  } cmd_e;

  // Opcode 00 borrows the two top address bits as a sub-command.
  function automatic cmd_e decode_cmd(input logic [1:0] op, input logic [1:0] ext);
    cmd_e c;
    unique case (op)
      2'b10:   c = CMD_READ;
      2'b01:   c = CMD_WRITE;
      2'b11:   c = CMD_ERASE;
      default: begin
        unique case (ext)
          2'b11:   c = CMD_EN_WR;
          2'b00:   c = CMD_DIS_WR;
          2'b01:   c = CMD_FILL_ALL;
          default: c = CMD_ERASE_ALL;
        endcase
      end
    endcase
    return c;
  endfunction

endpackage

// File: rtl/mw_sync.sv
module mw_sync #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);

  logic [N-1:0] meta;

  // Two-stage synchronizer shared by all serial pins, so they stay aligned.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end

endmodule

// File: rtl/mw_frame.sv
module mw_frame
  import mw_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_s,
  input  logic              sclk_rise,
  input  logic              sdi_s,
  input  logic              busy,
  input  logic [WORD_W-1:0] rd_word,
  output logic              start_seen,
  output logic              cmd_valid,
  output cmd_e              cmd,
  output logic [ADDR_W-1:0] addr,
  output logic [WORD_W-1:0] wdata,
  output logic              rd_active,
  output logic              rd_bit
);

  localparam int KEEP_W   = 2 + ADDR_W;          // opcode + address kept
  localparam int HDR_BITS = 3 + ADDR_W;          // opcode + ignored bit + address
  localparam int MAX_CNT  = (HDR_BITS > WORD_W) ? HDR_BITS : WORD_W;
  localparam int CNT_W    = $clog2(MAX_CNT + 1);
  localparam int IDX_W    = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] HDR_LAST = CNT_W'(HDR_BITS - 1);
  localparam logic [CNT_W-1:0] DAT_LAST = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] SKIP_POS = CNT_W'(2);

  typedef enum logic [2:0] {F_IDLE, F_HDR, F_DATA, F_READ, F_DONE} fst_e;

  fst_e              st;
  logic [CNT_W-1:0]  cnt;
  logic [KEEP_W-1:0] hsh;
  logic [WORD_W-1:0] dsh;
  logic [IDX_W-1:0]  idx;
  logic [KEEP_W-1:0] hsh_nx;
  logic [WORD_W-1:0] dsh_nx;
  cmd_e              dec;

  assign hsh_nx = {hsh[KEEP_W-2:0], sdi_s};
  assign dsh_nx = {dsh[WORD_W-2:0], sdi_s};
  assign dec    = decode_cmd(hsh_nx[KEEP_W-1 -: 2], hsh_nx[ADDR_W-1 -: 2]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= F_IDLE;
      cnt        <= '0;
      hsh        <= '0;
      dsh        <= '0;
      idx        <= '0;
      cmd        <= CMD_NONE;
      addr       <= '0;
      wdata      <= '0;
      start_seen <= 1'b0;
      cmd_valid  <= 1'b0;
    end else begin
      start_seen <= 1'b0;
      cmd_valid  <= 1'b0;
      if (!sel_s) begin
        st  <= F_IDLE;
        cnt <= '0;
      end else begin
        unique case (st)
          F_IDLE: begin
            if (sclk_rise && sdi_s && !busy) begin
              st         <= F_HDR;
              cnt        <= '0;
              start_seen <= 1'b1;
            end
          end
          F_HDR: begin
            if (sclk_rise) begin
              cnt <= cnt + 1'b1;
              if (cnt != SKIP_POS) hsh <= hsh_nx;
              if (cnt == HDR_LAST) begin
                addr <= hsh_nx[ADDR_W-1:0];
                cmd  <= dec;
                cnt  <= '0;
                unique case (dec)
                  CMD_READ: begin
                    st  <= F_READ;
                    idx <= IDX_W'(WORD_W - 1);
                  end
                  CMD_WRITE, CMD_FILL_ALL: st <= F_DATA;
                  default: begin
                    st        <= F_DONE;
                    cmd_valid <= 1'b1;
                  end
                endcase
              end
            end
          end
          F_DATA: begin
            if (sclk_rise) begin
              dsh <= dsh_nx;
              cnt <= cnt + 1'b1;
              if (cnt == DAT_LAST) begin
                wdata     <= dsh_nx;
                cmd_valid <= 1'b1;
                st        <= F_DONE;
              end
            end
          end
          F_READ: begin
            if (sclk_rise) begin
              if (idx == '0) st <= F_DONE;
              else           idx <= idx - 1'b1;
            end
          end
          default: ;  // F_DONE: wait for deselect
        endcase
      end
    end
  end

  assign rd_active = (st == F_READ) && sel_s;
  assign rd_bit    = rd_word[idx];

endmodule

// File: rtl/mw_prog.sv
module mw_prog #(
  parameter int PROG_CYCLES = 200,
  parameter int CSL_MIN     = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_s,
  input  logic start_seen,
  input  logic prog_start,
  output logic busy,
  output logic stat_en,
  output logic stat_val
);

  localparam int TW = $clog2(PROG_CYCLES + 1);
  localparam int LW = $clog2(CSL_MIN + 1);
  localparam logic [LW-1:0] LOW_SAT = LW'(CSL_MIN);

  logic [TW-1:0] tmr;
  logic [LW-1:0] lowcnt;
  logic          sel_q;
  logic          pend;
  logic          armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      tmr    <= '0;
      lowcnt <= '0;
      sel_q  <= 1'b0;
      pend   <= 1'b0;
      armed  <= 1'b0;
    end else begin
      sel_q <= sel_s;

      if (prog_start) begin
        busy <= 1'b1;
        tmr  <= TW'(PROG_CYCLES - 1);
      end else if (busy) begin
        if (tmr == '0) busy <= 1'b0;
        else           tmr  <= tmr - 1'b1;
      end

      if (!sel_s) begin
        armed <= 1'b0;
        if (lowcnt != LOW_SAT) lowcnt <= lowcnt + 1'b1;
      end else begin
        lowcnt <= '0;
        if (!sel_q && (lowcnt == LOW_SAT) && (busy || pend)) armed <= 1'b1;
      end

      if (prog_start)      pend <= 1'b1;
      else if (start_seen) pend <= 1'b0;

      if (start_seen) armed <= 1'b0;
    end
  end

  assign stat_en  = armed && sel_s;
  assign stat_val = !busy;

endmodule

// File: rtl/mw_eeprom_ctrl.sv
module mw_eeprom_ctrl
  import mw_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int PROG_CYCLES = 200,
  parameter int CSL_MIN     = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sclk,
  input  logic sdi,
  output logic sdo,
  output logic sdo_en
);

  localparam int ADDR_W = (WORD_W == 8) ? 8 : 7;
  localparam int DEPTH  = 1 << ADDR_W;

  logic              sel_s, sclk_s, sdi_s, sclk_d, sclk_rise;
  logic              start_seen, cmd_valid, rd_active, rd_bit;
  logic              busy, stat_en, stat_val, wel, prog_start;
  cmd_e              cmd;
  logic [ADDR_W-1:0] addr;
  logic [WORD_W-1:0] wdata, rd_word;
  logic [WORD_W-1:0] mem [DEPTH];

  mw_sync #(.N(3)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({cs, sclk, sdi}),
    .q     ({sel_s, sclk_s, sdi_s})
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_d <= 1'b0;
    else        sclk_d <= sclk_s;
  end

  assign sclk_rise = sclk_s && !sclk_d;

  mw_frame #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_frame (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_s      (sel_s),
    .sclk_rise  (sclk_rise),
    .sdi_s      (sdi_s),
    .busy       (busy),
    .rd_word    (rd_word),
    .start_seen (start_seen),
    .cmd_valid  (cmd_valid),
    .cmd        (cmd),
    .addr       (addr),
    .wdata      (wdata),
    .rd_active  (rd_active),
    .rd_bit     (rd_bit)
  );

  mw_prog #(.PROG_CYCLES(PROG_CYCLES), .CSL_MIN(CSL_MIN)) u_prog (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_s      (sel_s),
    .start_seen (start_seen),
    .prog_start (prog_start),
    .busy       (busy),
    .stat_en    (stat_en),
    .stat_val   (stat_val)
  );

  assign prog_start = cmd_valid && wel &&
                      (cmd == CMD_WRITE || cmd == CMD_ERASE ||
                       cmd == CMD_FILL_ALL || cmd == CMD_ERASE_ALL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel <= 1'b0;
    end else if (cmd_valid) begin
      if (cmd == CMD_EN_WR)  wel <= 1'b1;
      if (cmd == CMD_DIS_WR) wel <= 1'b0;
    end
  end

  // Array is updated as the program cycle starts; the timer then models its length.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (prog_start) begin
      unique case (cmd)
        CMD_WRITE:     mem[addr] <= wdata;
        CMD_ERASE:     mem[addr] <= '1;
        CMD_FILL_ALL:  for (int i = 0; i < DEPTH; i++) mem[i] <= wdata;
        CMD_ERASE_ALL: for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
        default: ;
      endcase
    end
  end

  assign rd_word = mem[addr];

  always_comb begin
    sdo    = 1'b0;
    sdo_en = 1'b0;
    if (rd_active) begin
      sdo    = rd_bit;
      sdo_en = 1'b1;
    end else if (stat_en) begin
      sdo    = stat_val;
      sdo_en = 1'b1;
    end
  end

endmodule

// File: rtl/mw_eeprom_ctrl_chk.sv
module mw_eeprom_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic cs,
  input logic sdo,
  input logic sdo_en,
  input logic busy,
  input logic rd_active,
  input logic stat_en,
  input logic wel,
  input logic prog_start
);

  // R9: a few clocks of deselect always leave data-out undriven
  a_r9_quiet_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs && !$past(cs) && !$past(cs, 2) && !$past(cs, 3)) |-> !sdo_en);

  // R6: no program cycle without the write-enable latch
  a_r6_program_needs_latch: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |-> wel);

  // R10: a new program cycle never starts on top of a running one
  a_r10_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |-> !busy);

  // R4: read data is never shifted out while a program cycle runs
  a_r4_read_not_during_program: assert property (@(posedge clk) disable iff (!rst_n)
    rd_active |-> !busy);

  // R8: status shown while busy drives the line low
  a_r8_busy_shown_low: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_en && busy && !rd_active) |-> (sdo_en && !sdo));

endmodule

bind mw_eeprom_ctrl mw_eeprom_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cs         (cs),
  .sdo        (sdo),
  .sdo_en     (sdo_en),
  .busy       (busy),
  .rd_active  (rd_active),
  .stat_en    (stat_en),
  .wel        (wel),
  .prog_start (prog_start)
);

// File: tb/test_mw_eeprom_ctrl.sv
module test_mw_eeprom_ctrl;

  localparam int WW   = 8;
  localparam int PROG = 40;
  localparam int CSL  = 3;
  localparam int HP   = 4;

  logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, sclk = 1'b0, sdi = 1'b0;
  logic sdo, sdo_en;
  int   n_chk = 0, n_fail = 0;
  bit   done = 1'b0;

  always #10 clk = ~clk;

  mw_eeprom_ctrl #(.WORD_W(WW), .PROG_CYCLES(PROG), .CSL_MIN(CSL)) i_mw_eeprom_ctrl (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sclk(sclk), .sdi(sdi), .sdo(sdo), .sdo_en(sdo_en)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sbit(input logic b);
    sclk = 1'b0; sdi = b; tick(HP);
    sclk = 1'b1; tick(HP);
  endtask

  task automatic deselect(input int n);
    sclk = 1'b0; sdi = 1'b0; cs = 1'b0; tick(n);
  endtask

  task automatic send_hdr(input logic [1:0] op, input logic [7:0] a);
    cs = 1'b1; tick(2);
    sbit(1'b1); sbit(op[1]); sbit(op[0]); sbit(1'b0);
    for (int i = 7; i >= 0; i--) sbit(a[i]);
  endtask

  task automatic send_word(input logic [7:0] d);
    for (int i = 7; i >= 0; i--) sbit(d[i]);
  endtask

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 5) & 255);
  endfunction

  // mode 0: a program cycle is expected; mode 1: none is expected
  task automatic settle(input int mode, input string req);
    bit found;
    deselect(CSL + 2);
    cs = 1'b1; tick(4);
    if (mode == 0) begin
      check(sdo_en && !sdo, "R8 busy status", {sdo_en, sdo}, 2'b10);
      found = 1'b0;
      for (int k = 0; k < PROG + 20; k++) begin
        tick(1);
        if (sdo_en && sdo) begin
          found = 1'b1;
          break;
        end
      end
      check(found, "R8 ready status", found, 1);
    end else begin
      check(!sdo_en, req, sdo_en, 0);
    end
    deselect(5);
  endtask

  task automatic expect_word(input logic [7:0] a, input logic [7:0] exp, input string req);
    logic [7:0] d;
    bit en_ok;
    send_hdr(2'b10, a);
    en_ok = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      sclk = 1'b0; tick(HP);
      d[i] = sdo;
      if (!sdo_en) en_ok = 1'b0;
      sclk = 1'b1; tick(HP);
    end
    sclk = 1'b0; tick(HP);
    check(en_ok && !sdo_en, "R4 read drive window", {en_ok, sdo_en}, 2'b10);
    check(d == exp, req, d, exp);
    deselect(5);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog (all requirements): actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    bit seen;
    tick(5);
    check(!sdo_en, "R1 reset output", sdo_en, 0);
    rst_n = 1'b1;
    tick(3);

    // R2: idle clocks while selected
    cs = 1'b1; tick(3);
    seen = 1'b0;
    for (int i = 0; i < 30; i++) begin
      sbit(1'b0);
      if (sdo_en) seen = 1'b1;
    end
    check(!seen, "R2 idle clocks", seen, 0);
    expect_word(8'd0, 8'hFF, "R2 R1 first read after idle");

    // R6: write while latch clear (R1 latch starts clear)
    send_hdr(2'b01, 8'd3); send_word(8'h12);
    settle(1, "R6 no program cycle");
    expect_word(8'd3, 8'hFF, "R6 word unchanged");

    // R5: enable writes
    send_hdr(2'b00, 8'hC0); deselect(5);

    // R3: full sweep
    for (int a = 0; a < 256; a++) begin
      send_hdr(2'b01, 8'(a)); send_word(pat(a));
      settle(0, "R3");
    end
    for (int a = 0; a < 256; a++) expect_word(8'(a), pat(a), "R3 readback");

    // R7: erase one word
    send_hdr(2'b11, 8'd10); settle(0, "R7");
    expect_word(8'd10, 8'hFF, "R7 erased word");
    expect_word(8'd11, pat(11), "R7 neighbour kept");

    // R11: abort mid-frame
    send_hdr(2'b01, 8'd20); sbit(1'b1); sbit(1'b0); sbit(1'b1);
    deselect(5);
    expect_word(8'd20, pat(20), "R11 aborted write");

    // R9: chip select held low through the cycle
    send_hdr(2'b01, 8'd30); send_word(8'h3C);
    sclk = 1'b0; sdi = 1'b0; cs = 1'b0;
    seen = 1'b0;
    for (int i = 0; i < PROG + 20; i++) begin
      tick(1);
      if (sdo_en) seen = 1'b1;
    end
    check(!seen, "R9 high impedance", seen, 0);
    expect_word(8'd30, 8'h3C, "R9 write landed");

    // R10: self-timed completion
    send_hdr(2'b01, 8'd31); send_word(8'hC3);
    deselect(PROG + 10);
    cs = 1'b1; tick(4);
    check(sdo_en && sdo, "R10 ready after idle wait", {sdo_en, sdo}, 2'b11);
    deselect(5);
    expect_word(8'd31, 8'hC3, "R10 write landed");

    // R5: fill all, erase all
    send_hdr(2'b00, 8'h40); send_word(8'h5A); settle(0, "R5");
    expect_word(8'd0,   8'h5A, "R5 fill all");
    expect_word(8'd77,  8'h5A, "R5 fill all");
    expect_word(8'd255, 8'h5A, "R5 fill all");
    send_hdr(2'b00, 8'h80); settle(0, "R5");
    expect_word(8'd0,   8'hFF, "R5 erase all");
    expect_word(8'd128, 8'hFF, "R5 erase all");
    expect_word(8'd255, 8'hFF, "R5 erase all");

    // R12: disable writes, then trailing bits that spell an enable
    send_hdr(2'b00, 8'h00);
    sbit(1'b1); sbit(1'b0); sbit(1'b0); sbit(1'b0); sbit(1'b1); sbit(1'b1);
    for (int i = 0; i < 6; i++) sbit(1'b0);
    deselect(5);
    send_hdr(2'b01, 8'd1); send_word(8'h00);
    settle(1, "R12 trailing bits ignored");
    expect_word(8'd1, 8'hFF, "R12 latch still clear");

    done = 1'b1;
    summary();
    $finish;
  end

endmodule